// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch

This block picks one of several free-running clock sources and drives it onto a single output clock. Changing the source never produces a short pulse. When the select code changes, the block first lets the running source finish its current high phase. It then holds the output low while the old gate turns off and the new gate turns on, and only after that lets the new source through. One source position is reserved for a PLL. When the PLL is the target, the output stays parked low until the PLL reports lock.

A controller in the reference clock domain coordinates every switch. Each source has its own gate, built from an enable chain that is clocked on that source's falling edge. The controller can only see a gate turn off if the old source keeps toggling. If the old source is stuck, a timeout counted in reference cycles clears that gate asynchronously, so the switch cannot hang. A busy flag tells the surrounding logic when a switch is in flight. A select change that arrives while a switch is in flight is held off and acted on once the current switch has completed. Generating the clocks and detecting whether they are present are handled elsewhere. If the selected source dies during normal running, the output follows it.

Top module: `glitchless_clk_mux`

## Requirements
- R1: While reset is asserted, clk_out is low and busy is high. After reset is released, source 0 is engaged, busy falls within 20 reference cycles, and clk_out then runs at the period of source 0.
- R2: After a change of sel between two running non-PLL sources, busy falls within 20 reference cycles. From then on, clk_out has the period of the source numbered by sel (sel is a binary index: 0 picks src_clk[0]).
- R3: Every high phase and every low phase of clk_out is at least as long as the shortest half-period among the running sources, so no runt pulse appears.
- R4: A source's gate opens only while every other gate is closed. During a switch, clk_out stays low continuously for at least one reference period between the last pulse of the old source and the first pulse of the new one.
- R5: When the target is the PLL position (PLL_SRC, default 3) and pll_lock is low, clk_out stays low and busy stays high. Once pll_lock rises, the PLL is engaged and busy falls within 30 reference cycles.
- R6: A change of sel made while busy is high does not redirect the switch already in progress. Once that switch completes, the block starts a new switch to the latest sel.
- R7: If the old source is stuck high, clk_out stays high for the first 28 reference cycles after the select change. Once TIMEOUT (default 32) reference cycles have passed, it is forced low asynchronously, and the switch then completes.
- R8: busy rises on the first reference rising edge at which sel differs from the engaged source. busy is low only while the engaged source's gate is open and no other gate is.
- R9: Presenting the engaged source's own index on sel starts no switch: busy stays low and clk_out keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the controller and the timeout |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk | input | N_SRC | Candidate source clocks, one bit per source |
| sel | input | SEL_W | Binary index of the requested source, synchronous to ref_clk |
| pll_lock | input | 1 | Lock flag of the source at position PLL_SRC, synchronized inside |
| clk_out | output | 1 | Switched output clock |
| busy | output | 1 | High while a switch is in progress |

## Verification
The bench drives every ordered pair of the non-PLL sources. Each source runs at a different period, so the output edge count shows which source is driving; a decoder or gating error would show up as the wrong rate. It watches every phase of the output for a runt, which would appear if a gate changed while its source was high. It also measures the low gap at each switch, which an overlap of two gates would shorten. It requests the PLL before lock and re-selects while parked there: a design that ignored lock would toggle early, and one that took the second request at once would skip the PLL handshake. Finally, it freezes the old source high and checks that the output falls neither before nor long after the timeout; a missing timeout would leave busy high forever.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_DROP      = 2'd1,
    ST_WAIT_LOCK = 2'd2,
    ST_RAISE     = 2'd3
  } sw_state_e;

  // Single set bit at position idx (callers cast to their width).
  function automatic logic [31:0] src_bit(input int unsigned idx);
    return 32'd1 << idx;
  endfunction

  // True once the drop wait has run for limit reference cycles.
  function automatic logic timeout_hit(input int unsigned count, input int unsigned limit);
    return count >= (limit - 1);
  endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/clksw_leg.sv
module clksw_leg #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic en
);

  logic [STAGES-1:0] chain_q;

  // Falling-edge chain: the gate only changes while its source is low.
  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], req};
  end

  assign en = chain_q[STAGES-1];

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int N_SRC   = 4,
  parameter int PLL_SRC = 3,
  parameter int TIMEOUT = 32,
  localparam int SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int CNT_W  = $clog2(TIMEOUT) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             lock_seen,
  input  logic [N_SRC-1:0] en_seen,
  output logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] kill,
  output logic             busy,
  output logic [SEL_W-1:0] cur_sel,
  output logic [SEL_W-1:0] tgt_sel,
  output logic             drop_phase,
  output logic             hold_for_lock
);

  sw_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sel_ok;
  logic             lock_ok;

  assign sel_ok  = int'(sel) < N_SRC;
  assign lock_ok = (int'(tgt_sel) != PLL_SRC) || lock_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RAISE;
      cur_sel <= '0;
      tgt_sel <= '0;
      req     <= N_SRC'(src_bit(0));
      kill    <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (sel_ok && (sel != cur_sel)) begin
            tgt_sel <= sel;
            req     <= '0;
            cnt_q   <= '0;
            state_q <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (en_seen == '0) begin
            kill    <= '0;
            state_q <= ST_WAIT_LOCK;
          end else if (kill == '0) begin
            if (timeout_hit(int'(cnt_q), TIMEOUT)) kill <= N_SRC'(src_bit(int'(cur_sel)));
            else                                   cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_WAIT_LOCK: begin
          if (lock_ok) begin
            req     <= N_SRC'(src_bit(int'(tgt_sel)));
            state_q <= ST_RAISE;
          end
        end
        ST_RAISE: begin
          if (en_seen[tgt_sel]) begin
            cur_sel <= tgt_sel;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign drop_phase    = (state_q == ST_DROP);
  assign hold_for_lock = (state_q == ST_WAIT_LOCK);

endmodule

// File: rtl/glitchless_clk_mux.sv
module glitchless_clk_mux #(
  parameter int N_SRC       = 4,
  parameter int PLL_SRC     = 3,
  parameter int TIMEOUT     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0] sel,
  input  logic             pll_lock,
  output logic             clk_out,
  output logic             busy
);

  logic [N_SRC-1:0] req_vec;
  logic [N_SRC-1:0] kill_vec;
  logic [N_SRC-1:0] leg_en;
  logic [N_SRC-1:0] leg_arst_n;
  logic [N_SRC-1:0] en_seen;
  logic             lock_seen;
  logic [SEL_W-1:0] cur_sel;
  logic [SEL_W-1:0] tgt_sel;
  logic             drop_phase;
  logic             hold_for_lock;

  clksw_ctrl #(
    .N_SRC   (N_SRC),
    .PLL_SRC (PLL_SRC),
    .TIMEOUT (TIMEOUT)
  ) u_ctrl (
    .clk           (ref_clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .lock_seen     (lock_seen),
    .en_seen       (en_seen),
    .req           (req_vec),
    .kill          (kill_vec),
    .busy          (busy),
    .cur_sel       (cur_sel),
    .tgt_sel       (tgt_sel),
    .drop_phase    (drop_phase),
    .hold_for_lock (hold_for_lock)
  );

  clksw_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_en_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (leg_en),
    .q     (en_seen)
  );

  clksw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_lock_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (pll_lock),
    .q     (lock_seen)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_leg
    assign leg_arst_n[i] = rst_n & ~kill_vec[i];
    clksw_leg #(.STAGES(SYNC_STAGES)) u_leg (
      .clk    (src_clk[i]),
      .arst_n (leg_arst_n[i]),
      .req    (req_vec[i]),
      .en     (leg_en[i])
    );
  end

  assign clk_out = |(src_clk & leg_en);

endmodule

// File: rtl/glitchless_clk_mux_chk.sv
module glitchless_clk_mux_chk
  import clksw_pkg::*;
#(
  parameter int N_SRC   = 4,
  parameter int PLL_SRC = 3,
  localparam int SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] sel,
  input logic             busy,
  input logic [SEL_W-1:0] cur_sel,
  input logic [SEL_W-1:0] tgt_sel,
  input logic [N_SRC-1:0] leg_en,
  input logic [N_SRC-1:0] en_seen,
  input logic [N_SRC-1:0] kill_vec,
  input logic             drop_phase,
  input logic             hold_for_lock,
  input logic             lock_seen
);

  // R4: never two gates open at once
  p_one_gate_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $onehot0(leg_en))
    else $error("two source gates open together");

  // R4: a gate opens only when all others are already closed
  for (genvar i = 0; i < N_SRC; i++) begin : g_rise
    always @(posedge leg_en[i]) begin
      if (rst_n) begin
        p_rise_alone_r4: assert ((leg_en & ~N_SRC'(src_bit(i))) == '0)
          else $error("gate %0d opened beside another", i);
      end
    end
  end

  // R5: parked low while waiting on the PLL lock
  p_lock_hold_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (hold_for_lock && (int'(tgt_sel) == PLL_SRC) && !lock_seen) |-> (leg_en == '0))
    else $error("gate open before PLL lock");

  // R6: the target of a switch in flight does not move
  p_target_held_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tgt_sel))
    else $error("target changed during switch");

  // R7: the forced clear only happens while waiting for the old gate
  p_kill_in_drop_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (|kill_vec) |-> drop_phase)
    else $error("forced clear outside drop phase");

  // R8: a differing select starts a switch on the next edge
  p_busy_rise_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!busy && (sel != cur_sel)) |=> busy)
    else $error("busy did not rise on select change");

  // R8: idle means exactly the engaged gate is open
  p_idle_engaged_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !busy |-> (en_seen == N_SRC'(src_bit(int'(cur_sel)))))
    else $error("idle with wrong gate state");

endmodule

bind glitchless_clk_mux glitchless_clk_mux_chk #(
  .N_SRC   (N_SRC),
  .PLL_SRC (PLL_SRC)
) u_chk (
  .ref_clk       (ref_clk),
  .rst_n         (rst_n),
  .sel           (sel),
  .busy          (busy),
  .cur_sel       (cur_sel),
  .tgt_sel       (tgt_sel),
  .leg_en        (leg_en),
  .en_seen       (en_seen),
  .kill_vec      (kill_vec),
  .drop_phase    (drop_phase),
  .hold_for_lock (hold_for_lock),
  .lock_seen     (lock_seen)
);

// File: tb/test_glitchless_clk_mux.sv
`timescale 1ns/1ps
module test_glitchless_clk_mux;

  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
  logic       freeze2 = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       pll_lock = 1'b0;
  logic       clk_out;
  logic       busy;
  logic [3:0] src_clk;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  assign src_clk = {s3, s2, s1, s0};

  glitchless_clk_mux i_glitchless_clk_mux (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .src_clk  (src_clk),
    .sel      (sel),
    .pll_lock (pll_lock),
    .clk_out  (clk_out),
    .busy     (busy)
  );

  always #5 ref_clk = ~ref_clk;
  always #2 s0 = ~s0;
  always #3 s1 = ~s1;
  always begin #4; if (!freeze2) s2 = ~s2; end
  always #5 s3 = ~s3;

  // periods in ns: 4, 6, 8, 10; shortest half-period 2 ns
  function automatic int exp_edges(input int per, input int win);
    return (win + per / 2) / per;
  endfunction

  int    edge_cnt = 0;
  real   last_t   = 0.0;
  real   min_hi   = 1.0e9;
  real   min_lo   = 1.0e9;

  always @(posedge clk_out) edge_cnt++;

  always @(clk_out) begin
    if (rst_n && last_t > 0.0) begin
      if (clk_out == 1'b0) begin if ($realtime - last_t < min_hi) min_hi = $realtime - last_t; end
      else                 begin if ($realtime - last_t < min_lo) min_lo = $realtime - last_t; end
    end
    last_t = $realtime;
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic count_window(input int per, input string tag);
    int c0;
    int n;
    int e;
    c0 = edge_cnt;
    #200;
    n = edge_cnt - c0;
    e = exp_edges(per, 200);
    check(n >= e - 1 && n <= e + 1, tag, "edge count in 200 ns", n, e);
  endtask

  task automatic run_switch(input int v, input int per);
    real lo_run;
    real max_run;
    real done_t;
    @(negedge ref_clk);
    sel = 2'(v);
    @(negedge ref_clk);
    check(busy == 1'b1, "R8", "busy after select change", int'(busy), 1);
    #0.1;
    lo_run = 0.0; max_run = 0.0; done_t = -1.0;
    for (int j = 0; j < 1000; j++) begin
      if (!clk_out) lo_run = lo_run + 0.25; else lo_run = 0.0;
      if (lo_run > max_run) max_run = lo_run;
      if (done_t < 0.0 && !busy) done_t = j * 0.25;
      #0.25;
    end
    check(done_t >= 0.0 && done_t <= 200.0, "R2", "switch time ns", int'(done_t), 200);
    check(max_run >= 10.0, "R4", "low gap ns", int'(max_run), 10);
    count_window(per, "R2");
  endtask

  initial begin
    #1000000;
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    int e0;
    bit any_busy;

    // R1: reset state
    repeat (3) @(negedge ref_clk);
    check(clk_out == 1'b0, "R1", "clk_out in reset", int'(clk_out), 0);
    check(busy == 1'b1, "R1", "busy in reset", int'(busy), 1);
    repeat (5) @(negedge ref_clk);
    check(clk_out == 1'b0, "R1", "clk_out late in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    cyc = 0;
    while (busy && cyc < 40) begin @(negedge ref_clk); cyc++; end
    check(cyc <= 20, "R1", "cycles to engage source 0", cyc, 20);
    count_window(4, "R1");

    // R2, R4: every ordered pair of non-PLL sources
    run_switch(1, 6);
    run_switch(2, 8);
    run_switch(0, 4);
    run_switch(2, 8);
    run_switch(1, 6);
    run_switch(0, 4);
    run_switch(1, 6);

    // R9: same index again
    @(negedge ref_clk);
    sel = 2'd1;
    any_busy = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge ref_clk);
      if (busy) any_busy = 1;
    end
    check(any_busy == 0, "R9", "busy on same select", int'(any_busy), 0);
    count_window(6, "R9");

    // R5: PLL target before lock
    @(negedge ref_clk);
    sel = 2'd3;
    @(negedge ref_clk);
    check(busy == 1'b1, "R8", "busy after PLL request", int'(busy), 1);
    repeat (12) @(negedge ref_clk);
    e0 = edge_cnt;
    repeat (28) @(negedge ref_clk);
    check(edge_cnt == e0, "R5", "edges before lock", edge_cnt - e0, 0);
    check(busy == 1'b1, "R5", "busy before lock", int'(busy), 1);

    // R6: re-select while parked
    sel = 2'd1;
    e0 = edge_cnt;
    repeat (20) @(negedge ref_clk);
    check(edge_cnt == e0, "R6", "edges after re-select while parked", edge_cnt - e0, 0);
    check(busy == 1'b1, "R6", "busy after re-select while parked", int'(busy), 1);
    pll_lock = 1'b1;
    cyc = 0;
    while (busy && cyc < 40) begin @(negedge ref_clk); cyc++; end
    check(cyc <= 30, "R5", "cycles from lock to PLL engaged", cyc, 30);
    repeat (2) @(negedge ref_clk);
    check(busy == 1'b1, "R6", "pending select started", int'(busy), 1);
    cyc = 0;
    while (busy && cyc < 40) begin @(negedge ref_clk); cyc++; end
    check(cyc <= 20, "R6", "cycles for pending switch", cyc, 20);
    count_window(6, "R6");

    // R5: PLL with lock already present
    run_switch(3, 10);

    // R7: old source stuck high
    run_switch(2, 8);
    @(posedge s2);
    #0.5;
    freeze2 = 1'b1;
    @(negedge ref_clk);
    check(clk_out == 1'b1, "R7", "clk_out with stuck source", int'(clk_out), 1);
    sel = 2'd0;
    repeat (28) @(negedge ref_clk);
    check(clk_out == 1'b1, "R7", "clk_out before timeout", int'(clk_out), 1);
    check(busy == 1'b1, "R7", "busy before timeout", int'(busy), 1);
    repeat (8) @(negedge ref_clk);
    check(clk_out == 1'b0, "R7", "clk_out after timeout", int'(clk_out), 0);
    cyc = 0;
    while (busy && cyc < 40) begin @(negedge ref_clk); cyc++; end
    check(cyc <= 30, "R7", "cycles to finish after timeout", cyc, 30);
    count_window(4, "R7");
    freeze2 = 1'b0;
    repeat (5) @(negedge ref_clk);

    // R3: no runt phase anywhere in the run
    check(min_hi >= 1.99, "R3", "shortest high phase ps", int'(min_hi * 1000.0), 2000);
    check(min_lo >= 1.99, "R3", "shortest low phase ps", int'(min_lo * 1000.0), 2000);

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule